// File: doc/BRIEF.md
# Protected Two-Bank Pin Function Multiplexer

This block holds the function selection for a row of configurable pads. Software programs two register banks over a simple word-wide register bus. The first-level bank gives each pin a short primary code. The second-level bank gives each pin a wider secondary code and also holds two selectors that pick the source driving each management-data (MDIO) channel. Every pin's primary and secondary codes are resolved combinationally into a single function number. Downstream routing logic consumes that number together with the per-channel MDIO source codes.

Each bank has its own write guard, and both guards are closed after reset. A guard opens when its own bus address with bit 0 set is written into it. It closes when its plain bus address is written into it. While a bank's guard is closed, its pin and MDIO registers keep their contents. The bus maps 2 KiB per bank. The first-level bank starts at local offset 0x000 and the second-level bank at 0x800. Each bank holds one word per pin from its base, a guard word at +0x400, and (second-level bank only) MDIO channel 0 and 1 selectors at +0x404 and +0x408. The guard keys are the full 32-bit bus address of the guard word, formed from the parameter `BASE_ADDR`.

Top module: `pinmux_ctrl`

## Requirements
- R1: After synchronous reset both guards are closed and read 0, every pin word and MDIO selector reads 0, every pin outputs function 0, and both MDIO source outputs are 0 (high-impedance source).
- R2: Writing a guard its key (BASE_ADDR + bank*0x800 + 0x400) closes it. Writing key|1 opens it. The guard word reads 1 while open and 0 while closed.
- R3: A guard write of any other value leaves that guard unchanged, and this includes the other bank's key values.
- R4: While a bank is closed, writes to its pin words and MDIO selectors do not change stored values or outputs. The other bank's state does not affect this.
- R5: The first-level code is write-data bits [3:0]. The upper bits are dropped and read back as zero. Codes 0 to 9 output that same function number on the pin's 7-bit field, pin p at bits [7p+6:7p].
- R6: First-level code 15 hands the pin to its second-level code, which is write-data bits [5:0]. Codes 0 to 61 output 10 plus that code. Codes 62 and 63 output 127 (no function). The second-level code has no effect on any other first-level code.
- R7: First-level codes 10 to 14 output 127 (no function).
- R8: Each MDIO selector stores write-data bits [2:0] and reads them back. Channel c drives mdio_src_o bits [3c+2:3c].
- R9: Words beyond the last pin, unmapped words, and the MDIO slots of the first-level bank read 0. Writes to them change no output.
- R10: Read data appears one cycle after the address is presented. A pin write changes pin_func_o immediately after the clock edge that takes it. A guard change applies to writes from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Local byte address (bank in bit 11, word in bits 10:2) |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | 32 | Registered read data |
| pin_func_o | output | NUM_PINS*7 | Resolved function number per pin |
| mdio_src_o | output | 6 | MDIO source selection, 3 bits per channel |

## Verification
Stored state and pin_func_o change on the edge that samples a write. The bench therefore drives each access at a falling edge and checks the outputs at the next falling edge. bus_rdata is registered, so a read presents its address at one falling edge and samples at the following one. One check also confirms that the old data is still present before that edge. Guard changes are checked by issuing a write in the cycle after the key write and reading the result back.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

    localparam int BANK_SPAN_W  = 11;
    localparam int ADDR_W       = BANK_SPAN_W + 1;
    localparam int WORD_W       = BANK_SPAN_W - 2;

    localparam int L1_W         = 4;
    localparam int L2_W         = 6;
    localparam int FUNC_W       = 7;
    localparam int MDIO_W       = 3;
    localparam int MDIO_CH      = 2;
    localparam int MDIO_CH_W    = (MDIO_CH > 1) ? $clog2(MDIO_CH) : 1;

    localparam int L1_DIRECT_MAX = 9;
    localparam int L1_CASCADE    = 15;
    localparam int L2_MAX        = 61;
    localparam int L2_FUNC_BASE  = L1_DIRECT_MAX + 1;

    localparam int PROT_WORD     = 256;
    localparam int MDIO_WORD0    = PROT_WORD + 1;

    localparam logic [FUNC_W-1:0] FUNC_NONE = '1;

    typedef enum logic [1:0] {
        HIT_NONE,
        HIT_CFG,
        HIT_PROT,
        HIT_MDIO
    } hit_e;

    typedef struct packed {
        hit_e              kind;
        logic              bank;
        logic [WORD_W-1:0] word;
    } dec_t;

    function automatic logic [FUNC_W-1:0] resolve_func(
        input logic [L1_W-1:0] l1,
        input logic [L2_W-1:0] l2
    );
        if (l1 <= L1_W'(L1_DIRECT_MAX))
            return FUNC_W'(l1);
        else if (l1 == L1_W'(L1_CASCADE)) begin
            if (l2 <= L2_W'(L2_MAX))
                return FUNC_W'(L2_FUNC_BASE) + FUNC_W'(l2);
            else
                return FUNC_NONE;
        end
        else
            return FUNC_NONE;
    endfunction

endpackage

// File: rtl/pmx_decode.sv
module pmx_decode
    import pmx_pkg::*;
#(
    parameter int NUM_PINS = 170
) (
    input  logic [ADDR_W-3:0] waddr_i,
    output dec_t              dec_o
);
    logic [WORD_W-1:0] word;
    logic              bank;

    assign word = waddr_i[WORD_W-1:0];
    assign bank = waddr_i[ADDR_W-3];

    always_comb begin
        dec_o.bank = bank;
        dec_o.word = word;
        if (word < WORD_W'(NUM_PINS))
            dec_o.kind = HIT_CFG;
        else if (word == WORD_W'(PROT_WORD))
            dec_o.kind = HIT_PROT;
        else if (bank && word >= WORD_W'(MDIO_WORD0) &&
                 word < WORD_W'(MDIO_WORD0 + MDIO_CH))
            dec_o.kind = HIT_MDIO;
        else
            dec_o.kind = HIT_NONE;
    end
endmodule

// File: rtl/pmx_protect.sv
module pmx_protect #(
    parameter logic [31:0] KEY = 32'h0000_0400
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we_i,
    input  logic [31:0] wdata_i,
    output logic        unlocked_o
);
    localparam logic [31:0] OPEN_KEY = KEY | 32'h1;

    logic unlocked_q;

    always_ff @(posedge clk) begin
        if (rst)
            unlocked_q <= 1'b0;
        else if (we_i && wdata_i == KEY)
            unlocked_q <= 1'b0;
        else if (we_i && wdata_i == OPEN_KEY)
            unlocked_q <= 1'b1;
    end

    assign unlocked_o = unlocked_q;

    a_r2_close_on_key: assert property (@(posedge clk) disable iff (rst)
        (we_i && wdata_i == KEY) |=> !unlocked_o);

    a_r2_open_on_key: assert property (@(posedge clk) disable iff (rst)
        (we_i && wdata_i == OPEN_KEY) |=> unlocked_o);

    a_r3_other_values_hold: assert property (@(posedge clk) disable iff (rst)
        (!we_i || (wdata_i != KEY && wdata_i != OPEN_KEY)) |=> $stable(unlocked_o));
endmodule

// File: rtl/pmx_cfg_bank.sv
module pmx_cfg_bank #(
    parameter int NUM_PINS = 170,
    parameter int CODE_W   = 4,
    localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en_i,
    input  logic                       unlocked_i,
    input  logic [IDX_W-1:0]           idx_i,
    input  logic [CODE_W-1:0]          wdata_i,
    output logic [NUM_PINS*CODE_W-1:0] codes_o,
    output logic [CODE_W-1:0]          rd_o
);
    logic [CODE_W-1:0] mem_q [NUM_PINS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PINS; i++)
                mem_q[i] <= '0;
        end
        else if (wr_en_i && unlocked_i) begin
            mem_q[idx_i] <= wdata_i;
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_flat
        assign codes_o[p*CODE_W +: CODE_W] = mem_q[p];
    end

    assign rd_o = mem_q[idx_i];

    a_r4_locked_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !unlocked_i) |=> $stable(codes_o));
endmodule

// File: rtl/pmx_mdio_sel.sv
module pmx_mdio_sel
    import pmx_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en_i,
    input  logic                      unlocked_i,
    input  logic [MDIO_CH_W-1:0]      ch_i,
    input  logic [MDIO_W-1:0]         wdata_i,
    output logic [MDIO_CH*MDIO_W-1:0] mdio_o,
    output logic [MDIO_W-1:0]         rd_o
);
    logic [MDIO_W-1:0] sel_q [MDIO_CH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < MDIO_CH; c++)
                sel_q[c] <= '0;
        end
        else if (wr_en_i && unlocked_i) begin
            sel_q[ch_i] <= wdata_i;
        end
    end

    for (genvar c = 0; c < MDIO_CH; c++) begin : g_flat
        assign mdio_o[c*MDIO_W +: MDIO_W] = sel_q[c];
    end

    assign rd_o = sel_q[ch_i];

    a_r4_locked_mdio_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !unlocked_i) |=> $stable(mdio_o));
endmodule

// File: rtl/pmx_resolve.sv
module pmx_resolve
    import pmx_pkg::*;
#(
    parameter int NUM_PINS = 170
) (
    input  logic [NUM_PINS*L1_W-1:0]   l1_i,
    input  logic [NUM_PINS*L2_W-1:0]   l2_i,
    output logic [NUM_PINS*FUNC_W-1:0] func_o
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [FUNC_W-1:0] f;
        assign f = resolve_func(l1_i[p*L1_W +: L1_W], l2_i[p*L2_W +: L2_W]);
        assign func_o[p*FUNC_W +: FUNC_W] = f;

        // R6/R7: result is a valid function number or the no-function code
        always_comb begin
            a_r6_func_range: assert (f <= FUNC_W'(L2_FUNC_BASE + L2_MAX) || f == FUNC_NONE);
        end
    end
endmodule

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
    import pmx_pkg::*;
#(
    parameter int          NUM_PINS  = 170,
    parameter logic [31:0] BASE_ADDR = 32'hA000_0000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    input  logic                       bus_we,
    output logic [31:0]                bus_rdata,
    output logic [NUM_PINS*FUNC_W-1:0] pin_func_o,
    output logic [MDIO_CH*MDIO_W-1:0]  mdio_src_o
);
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    dec_t                     dec;
    logic [1:0]               unlocked;
    logic [IDX_W-1:0]         idx;
    logic [MDIO_CH_W-1:0]     ch;
    logic [NUM_PINS*L1_W-1:0] l1_codes;
    logic [NUM_PINS*L2_W-1:0] l2_codes;
    logic [L1_W-1:0]          l1_rd;
    logic [L2_W-1:0]          l2_rd;
    logic [MDIO_W-1:0]        mdio_rd;
    logic                     cfg_we1, cfg_we2, mdio_we;

    pmx_decode #(.NUM_PINS(NUM_PINS)) u_dec (
        .waddr_i (bus_addr[ADDR_W-1:2]),
        .dec_o   (dec)
    );

    assign idx = dec.word[IDX_W-1:0];
    assign ch  = MDIO_CH_W'(dec.word - WORD_W'(MDIO_WORD0));

    for (genvar b = 0; b < 2; b++) begin : g_guard
        localparam logic [31:0] KEY = BASE_ADDR + (32'(b) << BANK_SPAN_W) + (32'(PROT_WORD) << 2);
        logic hit;
        assign hit = bus_we && dec.kind == HIT_PROT && dec.bank == 1'(b);
        pmx_protect #(.KEY(KEY)) u_prot (
            .clk        (clk),
            .rst        (rst),
            .we_i       (hit),
            .wdata_i    (bus_wdata),
            .unlocked_o (unlocked[b])
        );
    end

    assign cfg_we1 = bus_we && dec.kind == HIT_CFG && !dec.bank;
    assign cfg_we2 = bus_we && dec.kind == HIT_CFG &&  dec.bank;
    assign mdio_we = bus_we && dec.kind == HIT_MDIO;

    pmx_cfg_bank #(.NUM_PINS(NUM_PINS), .CODE_W(L1_W)) u_bank1 (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (cfg_we1),
        .unlocked_i (unlocked[0]),
        .idx_i      (idx),
        .wdata_i    (bus_wdata[L1_W-1:0]),
        .codes_o    (l1_codes),
        .rd_o       (l1_rd)
    );

    pmx_cfg_bank #(.NUM_PINS(NUM_PINS), .CODE_W(L2_W)) u_bank2 (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (cfg_we2),
        .unlocked_i (unlocked[1]),
        .idx_i      (idx),
        .wdata_i    (bus_wdata[L2_W-1:0]),
        .codes_o    (l2_codes),
        .rd_o       (l2_rd)
    );

    pmx_mdio_sel u_mdio (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (mdio_we),
        .unlocked_i (unlocked[1]),
        .ch_i       (ch),
        .wdata_i    (bus_wdata[MDIO_W-1:0]),
        .mdio_o     (mdio_src_o),
        .rd_o       (mdio_rd)
    );

    pmx_resolve #(.NUM_PINS(NUM_PINS)) u_res (
        .l1_i   (l1_codes),
        .l2_i   (l2_codes),
        .func_o (pin_func_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else begin
            unique case (dec.kind)
                HIT_CFG:  bus_rdata <= dec.bank ? 32'(l2_rd) : 32'(l1_rd);
                HIT_PROT: bus_rdata <= 32'(unlocked[dec.bank]);
                HIT_MDIO: bus_rdata <= 32'(mdio_rd);
                default:  bus_rdata <= '0;
            endcase
        end
    end

    a_r9_reserved_write_inert: assert property (@(posedge clk) disable iff (rst)
        (bus_we && dec.kind == HIT_NONE) |=> ($stable(pin_func_o) && $stable(mdio_src_o)));

    a_r9_reserved_read_zero: assert property (@(posedge clk) disable iff (rst)
        (dec.kind == HIT_NONE) |=> (bus_rdata == 32'h0));
endmodule

// File: tb/pinmux_ctrl_tb.sv
module pinmux_ctrl_tb;
    localparam int          NP   = 170;
    localparam logic [31:0] BASE = 32'hA000_0000;
    localparam logic [31:0] K1   = BASE + 32'h400;
    localparam logic [31:0] K2   = BASE + 32'hC00;
    localparam logic [11:0] P1   = 12'h400;
    localparam logic [11:0] P2   = 12'hC00;
    localparam logic [11:0] M0   = 12'hC04;
    localparam logic [11:0] M1   = 12'hC08;

    logic              clk = 0;
    logic              rst = 1;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_we = 0;
    logic [31:0]       bus_rdata;
    logic [NP*7-1:0]   pin_func_o;
    logic [5:0]        mdio_src_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pinmux_ctrl #(.NUM_PINS(NP), .BASE_ADDR(BASE)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_rdata  (bus_rdata),
        .pin_func_o (pin_func_o),
        .mdio_src_o (mdio_src_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] a1(input int p); return 12'(p * 4); endfunction
    function automatic logic [11:0] a2(input int p); return 12'h800 + 12'(p * 4); endfunction
    function automatic logic [31:0] pf(input int p); return 32'(pin_func_o[p*7 +: 7]); endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(P1, d);       chk("R1 guard1", d, 0);
        rd(P2, d);       chk("R1 guard2", d, 0);
        rd(a1(0), d);    chk("R1 l1 word", d, 0);
        rd(a2(169), d);  chk("R1 l2 word", d, 0);
        rd(M1, d);       chk("R1 mdio1", d, 0);
        chk("R1 pin0", pf(0), 0);
        chk("R1 pin169", pf(169), 0);
        chk("R1 mdio out", 32'(mdio_src_o), 0);
    endtask

    task automatic t_locked();
        logic [31:0] d;
        wr(a1(3), 5);
        rd(a1(3), d);    chk("R4 locked l1 write", d, 0);
        chk("R4 locked pin out", pf(3), 0);
        wr(P1, K1 | 1);
        rd(P1, d);       chk("R2 guard1 open", d, 1);
        wr(a2(3), 7);
        rd(a2(3), d);    chk("R4 l2 locked while l1 open", d, 0);
        wr(M0, 4);
        chk("R4 locked mdio out", 32'(mdio_src_o), 0);
        wr(a1(3), 5);
        rd(a1(3), d);    chk("R4 open l1 write", d, 5);
        chk("R5 pin3 direct", pf(3), 5);
        wr(P2, K2 | 1);
        rd(P2, d);       chk("R2 guard2 open", d, 1);
    endtask

    task automatic t_keys();
        logic [31:0] d;
        wr(P1, K2 | 1);
        rd(P1, d);       chk("R3 foreign key", d, 1);
        wr(P1, 32'h1234_5678);
        rd(P1, d);       chk("R3 junk value", d, 1);
        wr(P1, K1);
        rd(P1, d);       chk("R2 guard1 closed", d, 0);
        wr(P1, K1 | 3);
        rd(P1, d);       chk("R3 near key", d, 0);
        wr(a1(4), 2);
        rd(a1(4), d);    chk("R4 relocked write", d, 0);
        wr(P1, K1 | 1);
    endtask

    task automatic t_level1();
        logic [31:0] d;
        wr(a1(0), 32'hFFFF_FFF9);
        rd(a1(0), d);    chk("R5 upper bits dropped", d, 9);
        chk("R5 pin0 code9", pf(0), 9);
        wr(a1(169), 0);
        chk("R5 pin169 code0", pf(169), 0);
        wr(a1(12), 12);
        chk("R7 code12", pf(12), 127);
        wr(a1(12), 10);
        chk("R7 code10", pf(12), 127);
        wr(a1(12), 14);
        chk("R7 code14", pf(12), 127);
    endtask

    task automatic t_level2();
        logic [31:0] d;
        wr(a1(10), 15);
        wr(a2(10), 0);
        chk("R6 l2 code0", pf(10), 10);
        wr(a2(10), 61);
        chk("R6 l2 code61", pf(10), 71);
        wr(a2(10), 62);
        chk("R6 l2 code62", pf(10), 127);
        wr(a2(10), 32'hFFFF_FFFF);
        rd(a2(10), d);   chk("R6 l2 width", d, 63);
        chk("R6 l2 code63", pf(10), 127);
        wr(a1(11), 3);
        wr(a2(11), 20);
        chk("R6 l2 ignored under direct", pf(11), 3);
    endtask

    task automatic t_mdio();
        logic [31:0] d;
        wr(M0, 5);
        wr(M1, 7);
        chk("R8 mdio out", 32'(mdio_src_o), 32'h3D);
        rd(M0, d);       chk("R8 mdio0 read", d, 5);
        wr(M0, 32'hFFFF_FFFA);
        rd(M0, d);       chk("R8 mdio0 width", d, 2);
        chk("R8 mdio out2", 32'(mdio_src_o), 32'h3A);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wr(a1(170), 9);
        rd(a1(170), d);  chk("R9 past last pin", d, 0);
        chk("R9 pin169 unchanged", pf(169), 0);
        wr(12'h404, 6);
        rd(12'h404, d);  chk("R9 l1 mdio slot", d, 0);
        chk("R9 mdio unchanged", 32'(mdio_src_o), 32'h3A);
        rd(12'h500, d);  chk("R9 gap word", d, 0);
        rd(12'hC0C, d);  chk("R9 after mdio", d, 0);
    endtask

    task automatic t_timing();
        logic [31:0] d;
        rd(a1(0), d);
        @(negedge clk);
        bus_addr = a1(3);
        chk("R10 old data before edge", bus_rdata, 9);
        @(negedge clk);
        chk("R10 new data after edge", bus_rdata, 5);
        @(negedge clk);
        bus_addr = a1(5); bus_wdata = 7; bus_we = 1;
        chk("R10 pin before edge", pf(5), 0);
        @(negedge clk);
        bus_we = 0;
        chk("R10 pin after edge", pf(5), 7);
        @(negedge clk);
        bus_addr = P1; bus_wdata = K1; bus_we = 1;
        @(negedge clk);
        bus_addr = a1(5); bus_wdata = 2;
        @(negedge clk);
        bus_we = 0;
        chk("R10 write after close", pf(5), 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_locked();
        t_keys();
        t_level1();
        t_level2();
        t_mdio();
        t_reserved();
        t_timing();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule